// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a synchronous host to an external asynchronous static RAM of 256K words by 16 bits that has a single shared data bus. The host makes one request at a time on a simple request/acknowledge port. Each request carries a word address, write data, a per-byte enable and a read/write flag. The controller turns each request into a sequence of memory control levels: active-low chip select, write enable, output enable, one active-low strobe per byte lane, and an enable for the data-bus tristate driver.

The length of each phase is a parameter counted in host clock cycles, so one netlist can be set up for faster or slower memory grades. These parameters are:

- the read access window
- the write pulse
- the data setup inside the write pulse
- the turnaround gap after a read

During a write, output enable stays high for the whole cycle, which allows the shorter write pulse. Byte strobes mask the lanes that are not enabled. The turnaround gap keeps the controller's driver off the bus while the memory is still releasing it after a read.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, chip select, write enable, output enable and both byte strobes are high, the bus driver enable is low and the acknowledge is low.
- R2: A request is taken only when the controller is idle. The host holds `req` until it sees `ack`. Exactly one memory access is made per request.
- R3: A read drives chip select and output enable low, with write enable high, for exactly T_READ cycles. The bus is sampled at the end of the last of those cycles. `ack` and `rdata` appear in the next cycle, T_READ+1 rising edges after the edge that accepted the request.
- R4: During a write, output enable is high in every cycle. Write enable is low for exactly T_WP consecutive cycles.
- R5: Chip select is low, and address and strobes are held unchanged, for one cycle before write enable falls and for one cycle after it rises. `ack` is given in that trailing cycle, T_WP+2 rising edges after acceptance.
- R6: The bus driver enable is high only while write enable and chip select are low, and only during the last min(T_DS, T_WP) cycles of the pulse. Write data is therefore valid when the write ends.
- R7: Bit 0 of `req_be` maps to strobe `mem_bs_n[0]` and data bits 7:0. Bit 1 maps to `mem_bs_n[1]` and bits 15:8. A write changes only the enabled lanes. A write with `req_be` = 00 leaves the memory unchanged.
- R8: On a read, the bits of any lane whose enable is 0 are returned as zero.
- R9: After a read, chip select stays high for at least T_TURN+1 cycles before the next access begins. The controller never drives the bus while the memory is still driving it.
- R10: `ack` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables |
| ack | output | 1 | Request complete pulse |
| rdata | output | 16 | Read data, valid with ack |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bs_n | output | 2 | Byte strobes, active low, bit 0 lower |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Tristate driver enable for the data bus |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The bench aims at partial-lane writes and reads, including the all-lanes-off case. A design that ignores a strobe would corrupt the neighbouring byte. A design that skips masking would return bus garbage in the unused lane. A behavioural memory that drives the bus with a release delay catches a missing turnaround gap as bus contention. It also catches write data that is not valid when the write ends, because the wrong bytes are stored. Pulse-width, driver-window and latency counts expose off-by-one errors in the phase counters. Counting accesses against requests exposes a request taken twice while the host still holds it.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSET   = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4,
    ST_TURN   = 3'd5
  } ctl_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
// Down-counter that times one controller phase; last is high on its final cycle.
module sram_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_mask.sv
// Per-lane strobe generation and read-data masking.
module sram_lane_mask #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic [LANES-1:0]  be,
  input  logic              active,
  input  logic [DATA_W-1:0] raw,
  output logic [LANES-1:0]  strb_n,
  output logic [DATA_W-1:0] masked
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign strb_n[l]          = !(active && be[l]);
    assign masked[l*8 +: 8]   = be[l] ? raw[l*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int T_READ = 2,
  parameter int T_WP   = 2,
  parameter int T_DS   = 1,
  parameter int T_TURN = 1,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_bs_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int MAX_T  = imax(imax(T_READ, T_WP), imax(T_TURN, 1));
  localparam int CNT_W  = $clog2(MAX_T + 1);
  localparam int DS_EFF = imax(imin(T_DS, T_WP), 1);
  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(T_READ - 1);
  localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(T_WP - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(T_TURN - 1);
  localparam logic [CNT_W-1:0] DS_LIM    = CNT_W'(DS_EFF);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  ctl_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rd_masked;
  logic [LANES-1:0]  be_q, strb_n;
  logic              rd_ack_q, rd_ack_d;
  logic              cnt_load, cnt_last, lat_en, cap_en, cs_act;
  logic [CNT_W-1:0]  cnt_val, cnt_load_val;

  sram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .cnt      (cnt_val),
    .last     (cnt_last)
  );

  sram_lane_mask #(.DATA_W(DATA_W)) u_mask (
    .be     (be_q),
    .active (cs_act),
    .raw    (mem_dq_in),
    .strb_n (strb_n),
    .masked (rd_masked)
  );

  // next-state
  always_comb begin
    state_d      = state_q;
    cnt_load     = 1'b0;
    cnt_load_val = '0;
    rd_ack_d     = 1'b0;
    lat_en       = 1'b0;
    cap_en       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          lat_en = 1'b1;
          if (req_we) begin
            state_d = ST_WSET;
          end else begin
            state_d      = ST_READ;
            cnt_load     = 1'b1;
            cnt_load_val = RD_LOAD;
          end
        end
      end
      ST_READ: begin
        if (cnt_last) begin
          cap_en       = 1'b1;
          rd_ack_d     = 1'b1;
          state_d      = ST_TURN;
          cnt_load     = 1'b1;
          cnt_load_val = TURN_LOAD;
        end
      end
      ST_WSET: begin
        state_d      = ST_WPULSE;
        cnt_load     = 1'b1;
        cnt_load_val = WP_LOAD;
      end
      ST_WPULSE: begin
        if (cnt_last) state_d = ST_WHOLD;
      end
      ST_WHOLD: state_d = ST_IDLE;
      ST_TURN: begin
        if (cnt_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q  <= ST_IDLE;
      rd_ack_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rd_ack_q <= rd_ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (lat_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= rd_masked;
    end
  end

  // memory-side decode
  assign cs_act     = (state_q == ST_READ) || (state_q == ST_WSET) ||
                      (state_q == ST_WPULSE) || (state_q == ST_WHOLD);
  assign mem_cs_n   = !cs_act;
  assign mem_oe_n   = (state_q != ST_READ);
  assign mem_we_n   = (state_q != ST_WPULSE);
  assign mem_bs_n   = strb_n;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (state_q == ST_WPULSE) && (cnt_val < DS_LIM);
  assign ack        = (state_q == ST_WHOLD) || rd_ack_q;
  assign rdata      = rdata_q;

  // assertions
  p_oe_high_in_write_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !mem_we_n |-> mem_oe_n);

  p_drive_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_dq_oe |-> (!mem_we_n && !mem_cs_n));

  p_setup_stable_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_bs_n) && $past(!mem_cs_n)));

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(mem_we_n) |-> (!mem_cs_n && $stable(mem_addr) && $stable(mem_bs_n)));

  p_turn_quiet_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(mem_oe_n) |-> (mem_cs_n && !mem_dq_oe));

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    ack |=> !ack);

endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;

  localparam int T_READ = 3;
  localparam int T_WP   = 3;
  localparam int T_DS   = 2;
  localparam int T_TURN = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_we;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        ack;
  logic [15:0] rdata;
  logic [17:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_bs_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;

  sram_lane_ctrl #(.T_READ(T_READ), .T_WP(T_WP), .T_DS(T_DS), .T_TURN(T_TURN)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rdata(rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_bs_n(mem_bs_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // behavioural memory (aliased on the low 10 address bits) and reference copy
  logic [15:0] model_mem [1024];
  logic [15:0] ref_mem   [1024];

  logic [1:0]  drv_q = 2'b00;
  bit          in_wr = 0;
  logic [17:0] wr_addr;
  logic [1:0]  wr_bs;
  logic [15:0] wr_dat;
  bit          wr_valid;
  logic [17:0] prev_addr;
  logic [1:0]  prev_bs;
  bit          prev_cs_low = 0;
  bit          prev_oe_low = 0;
  int          we_run = 0;
  int          oe_run = 0;
  int          gap = 0;
  bit          gap_on = 0;
  int          n_access = 0;
  bit          model_on = 0;

  always @(negedge clk) begin
    if (model_on) begin
      // R9: the controller must not drive while the model still drives
      if (drv_q != 2'b00 && mem_dq_oe)
        chk(0, "R9 bus contention", {31'd0, mem_dq_oe}, 32'd0);
      if (!mem_cs_n && !prev_cs_low) n_access++;
      // turnaround gap after a read
      if (prev_oe_low && mem_oe_n) begin gap = 0; gap_on = 1; end
      if (gap_on) begin
        if (mem_cs_n) gap++;
        else begin
          chk(gap >= T_TURN + 1, "R9 turnaround gap", gap, T_TURN + 1);
          gap_on = 0;
        end
      end
      // read drive, registered half a cycle
      for (int l = 0; l < 2; l++) begin
        if (!mem_cs_n && mem_we_n && !mem_oe_n && !mem_bs_n[l]) begin
          drv_q[l] = 1'b1;
          mem_dq_in[l*8 +: 8] = model_mem[mem_addr[9:0]][l*8 +: 8];
        end else begin
          drv_q[l] = 1'b0;
          mem_dq_in[l*8 +: 8] = 8'hC3;
        end
      end
      // write overlap
      if (!mem_cs_n && !mem_we_n) begin
        if (!in_wr) begin
          chk(prev_cs_low && prev_addr == mem_addr && prev_bs == mem_bs_n,
              "R5 setup before WE falls", {12'd0, mem_addr, mem_bs_n}, {12'd0, prev_addr, prev_bs});
          we_run = 0; oe_run = 0;
        end
        in_wr = 1; we_run++;
        if (mem_dq_oe) oe_run++;
        chk(mem_oe_n, "R4 OE high in write", {31'd0, mem_oe_n}, 32'd1);
        wr_addr = mem_addr; wr_bs = mem_bs_n; wr_dat = mem_dq_out; wr_valid = mem_dq_oe;
      end else if (in_wr) begin
        in_wr = 0;
        chk(we_run == T_WP, "R4 write pulse width", we_run, T_WP);
        chk(oe_run == T_DS, "R6 driver window", oe_run, T_DS);
        chk(wr_valid, "R6 data valid at end of write", {31'd0, wr_valid}, 32'd1);
        chk(!mem_cs_n && mem_addr == wr_addr && mem_bs_n == wr_bs,
            "R5 hold after WE rises", {12'd0, mem_addr, mem_bs_n}, {12'd0, wr_addr, wr_bs});
        for (int l = 0; l < 2; l++)
          if (!wr_bs[l] && wr_valid) model_mem[wr_addr[9:0]][l*8 +: 8] = wr_dat[l*8 +: 8];
      end
      prev_cs_low = !mem_cs_n;
      prev_oe_low = !mem_oe_n;
      prev_addr   = mem_addr;
      prev_bs     = mem_bs_n;
    end
  end

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  int n_req = 0;

  task automatic access(input bit we, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] be, input bit rand_gap);
    int lat;
    logic [15:0] got, exp;
    @(negedge clk);
    if (rand_gap) repeat ($urandom_range(0, 3)) @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    n_req++;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!ack && lat < 40);
    got = rdata;
    req = 0;
    if (we) begin
      chk(lat == T_WP + 2, "R5 write ack latency", lat, T_WP + 2);
      ref_mem[a[9:0]] = (ref_mem[a[9:0]] & ~lane_mask(be)) | (d & lane_mask(be));
    end else begin
      chk(lat == T_READ + 1, "R3 read ack latency", lat, T_READ + 1);
      exp = ref_mem[a[9:0]] & lane_mask(be);
      chk(got == exp, be == 2'b11 ? "R3 read data" : "R8 masked read data", got, exp);
    end
    @(negedge clk);
    chk(!ack, "R10 ack single pulse", {31'd0, ack}, 32'd0);
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        chk(0, "watchdog", wd, 150000);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [17:0] a0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin model_mem[i] = '0; ref_mem[i] = '0; end
    mem_dq_in = 16'hC3C3;
    req = 0; req_we = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_bs_n == 2'b11 && !mem_dq_oe && !ack,
        "R1 reset outputs", {26'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe},
        {26'd0, 6'b111110});
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_bs_n == 2'b11 && !mem_dq_oe && !ack,
        "R1 idle after reset", {26'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe},
        {26'd0, 6'b111110});
    model_on = 1;

    a0 = 18'h2A5F1;
    access(1, a0, 16'h1234, 2'b11, 0);      // R3 full write then read
    access(0, a0, 16'h0000, 2'b11, 0);
    access(1, a0, 16'hBEEF, 2'b01, 0);      // R7 lower lane only
    access(0, a0, 16'h0000, 2'b11, 0);
    access(0, a0, 16'h0000, 2'b10, 0);      // R8 upper lane only
    access(1, a0, 16'hFFFF, 2'b00, 0);      // R7 no lanes: memory unchanged
    access(0, a0, 16'h0000, 2'b11, 0);
    access(0, a0, 16'h0000, 2'b00, 0);      // R8 all lanes off returns zero
    access(1, a0 + 1, 16'h5A5A, 2'b10, 0);  // R9 read followed at once by write
    access(0, a0 + 1, 16'h0000, 2'b11, 0);

    for (int k = 0; k < 200; k++) begin
      access($urandom_range(0, 1), 18'($urandom), 16'($urandom), 2'($urandom), 1);
    end

    repeat (4) @(negedge clk);
    chk(n_access == n_req, "R2 one access per request", n_access, n_req);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule